// File: doc/BRIEF.md
# Staged Parallel-to-Serial Converter

The block turns a parallel word into a bit stream using two register stages. A holding register captures the parallel input word when its capture strobe rises. A separate shift register can take a copy of the holding register, be cleared, or move bits one place toward its top stage on each rising edge of a shift strobe. Only the top stage of the shift register leaves the block, as the serial output.

Both strobes are slow control lines from outside the system clock domain. Each is synchronised into the system clock and turned into a one-cycle rising-edge pulse. The copy and clear controls are active-low levels that are sampled on every system clock. While either of them is low, shifting is suppressed. Driving both low at the same time is an error. In that case the block raises a flag and forces the shift register to zero.

Top module: `staged_piso`

## Requirements
- R1: A rising edge on `cap_strobe` loads `par_in` into the holding register, whatever the levels of `copy_n`, `clear_n` and `shift_strobe`.
- R2: The holding register changes only on a capture edge. Shift edges, copies and clears leave it unchanged.
- R3: While `copy_n` is 0 and `clear_n` is 1, the shift register takes the holding register contents on every system clock. No shift edge is needed.
- R4: While `clear_n` is 0 and `copy_n` is 1, the shift register is held at all zeros.
- R5: With `copy_n` and `clear_n` both 1, a rising edge on `shift_strobe` moves bit n-1 to bit n and puts `ser_in` into bit 0.
- R6: `ser_out` is the top bit (bit 7 by default) of the shift register. After a copy, successive shift edges present the copied word from bit 7 down to bit 0, and then the `ser_in` bits in the order they entered.
- R7: While `copy_n` and `clear_n` are both 0, `fault` is 1 from the next clock and the shift register is all zeros. `fault` is 0 at every other time.
- R8: If a capture edge falls in the same cycle as a copy, the shift register receives the newly captured word, not the old contents of the holding register.
- R9: A shift edge has no effect while `copy_n` or `clear_n` is 0, and a capture edge never shifts the shift register.
- R10: Each strobe passes through a two-flop synchroniser and an edge register. Its action takes place on the third rising clock edge after the strobe is first sampled high.
- R11: `rst_n` low clears the holding register, the shift register and `fault` at once. Reset is released synchronously to the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | 8 | Parallel data word |
| cap_strobe | input | 1 | Capture strobe; a rising edge loads the holding register |
| shift_strobe | input | 1 | Shift strobe; a rising edge shifts the shift register |
| ser_in | input | 1 | Serial data entering bit 0 |
| copy_n | input | 1 | Active-low level: copy the holding register into the shift register |
| clear_n | input | 1 | Active-low level: clear the shift register |
| ser_out | output | 1 | Top bit of the shift register |
| fault | output | 1 | High while copy and clear are both asserted |

## Verification
The capture edge and a copy can fall in the same cycle. The bench provokes this by holding `copy_n` low for exactly the one clock in which the synchronised capture edge fires, with a new word on `par_in`. It then shifts the register out and expects the new word rather than the old one. Shift edges during a held copy or clear, and capture edges during a clear, are also applied on purpose. Their effect, or lack of it, is judged from the bits that are shifted out afterwards. Every 8-bit word is copied and shifted out, followed by its complement entered serially.

// File: rtl/staged_piso_pkg.sv
package staged_piso_pkg;
  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_COPY  = 2'd1,
    SR_CLEAR = 2'd2,
    SR_FAULT = 2'd3
  } sr_ctl_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  // R10: an edge pulse lasts exactly one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/hold_stage.sv
module hold_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_rise,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] hold_next,
  output logic [WIDTH-1:0] hold_q
);
  always_comb begin
    hold_next = hold_q;
    if (cap_rise) hold_next = par_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (cap_rise) hold_q <= hold_next;
  end

  // R2: without a capture edge the holding register keeps its value
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(hold_q));
  // R1: a capture edge stores the word on the input
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> hold_q == $past(par_in));
endmodule

// File: rtl/shift_stage.sv
module shift_stage
  import staged_piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copy_n,
  input  logic             clear_n,
  input  logic             shift_rise,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] copy_src,
  output logic [WIDTH-1:0] sr_q,
  output logic             fault_q
);
  sr_ctl_e          ctl;
  logic [WIDTH-1:0] sr_d;
  logic             sr_en;
  logic             fault_d;

  always_comb begin
    unique case ({copy_n, clear_n})
      2'b00:   ctl = SR_FAULT;
      2'b01:   ctl = SR_COPY;
      2'b10:   ctl = SR_CLEAR;
      default: ctl = SR_HOLD;
    endcase
  end

  always_comb begin
    sr_d    = sr_q;
    sr_en   = 1'b1;
    fault_d = 1'b0;
    case (ctl)
      SR_FAULT: begin sr_d = '0; fault_d = 1'b1; end
      SR_CLEAR: sr_d = '0;
      SR_COPY:  sr_d = copy_src;
      default: begin
        sr_en = shift_rise;
        sr_d  = {sr_q[WIDTH-2:0], ser_in};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      if (sr_en) sr_q <= sr_d;
      fault_q <= fault_d;
    end
  end

  // R4: clear alone empties the register
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && copy_n) |=> sr_q == '0);
  // R7: both controls low raises the flag and zeroes the register
  a_r7_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && !copy_n) |=> (fault_q && sr_q == '0));
  // R7: flag stays low otherwise
  a_r7_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n || copy_n) |=> !fault_q);
  // R3: copy takes the source word
  a_r3_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_n && clear_n) |=> sr_q == $past(copy_src));
  // R9: without a shift edge and with both controls high nothing moves
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_n && clear_n && !shift_rise) |=> $stable(sr_q));
endmodule

// File: rtl/staged_piso.sv
module staged_piso #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_strobe,
  input  logic             shift_strobe,
  input  logic             ser_in,
  input  logic             copy_n,
  input  logic             clear_n,
  output logic             ser_out,
  output logic             fault
);
  localparam int TOP = WIDTH - 1;

  logic             rst_n_meta, rst_n_sync;
  logic             cap_rise, shift_rise;
  logic [WIDTH-1:0] hold_next, hold_q, sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_n_meta <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_n_meta <= 1'b1;
      rst_n_sync <= rst_n_meta;
    end
  end

  strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_cap_edge (
    .clk(clk), .rst_n(rst_n_sync), .strobe(cap_strobe), .rise(cap_rise));

  strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_shift_edge (
    .clk(clk), .rst_n(rst_n_sync), .strobe(shift_strobe), .rise(shift_rise));

  hold_stage #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n_sync), .cap_rise(cap_rise), .par_in(par_in),
    .hold_next(hold_next), .hold_q(hold_q));

  shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n_sync), .copy_n(copy_n), .clear_n(clear_n),
    .shift_rise(shift_rise), .ser_in(ser_in), .copy_src(hold_next),
    .sr_q(sr_q), .fault_q(fault));

  assign ser_out = sr_q[TOP];

  // R8: a copy during a capture edge receives the new word
  a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cap_rise && !copy_n && clear_n) |=> sr_q == $past(par_in));
  // R2: a shift edge does not touch the holding register
  a_r2_shift_no_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (shift_rise && !cap_rise) |=> $stable(hold_q));
endmodule

// File: tb/staged_piso_tb.sv
module staged_piso_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] par_in;
  logic         cap_strobe, shift_strobe, ser_in, copy_n, clear_n;
  logic         ser_out, fault;
  int           total = 0;
  int           bad = 0;
  bit           done = 0;

  always #5 clk = ~clk;

  staged_piso u_dut (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_strobe(cap_strobe),
    .shift_strobe(shift_strobe), .ser_in(ser_in), .copy_n(copy_n),
    .clear_n(clear_n), .ser_out(ser_out), .fault(fault));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [W-1:0] v);
    par_in = v; cap_strobe = 1'b1; tick(4);
    cap_strobe = 1'b0; tick(4);
  endtask

  task automatic shift_one(input logic b);
    ser_in = b; shift_strobe = 1'b1; tick(4);
    shift_strobe = 1'b0; tick(4);
  endtask

  task automatic do_copy();
    copy_n = 1'b0; tick(2); copy_n = 1'b1; tick(1);
  endtask

  // shifts out W bits, comparing with v from the top bit down, feeding fill
  task automatic drain(input string req, input logic [W-1:0] v, input logic [W-1:0] fill);
    for (int i = W - 1; i >= 0; i--) begin
      chk(req, ser_out, v[i]);
      shift_one(fill[i]);
    end
  endtask

  initial begin
    rst_n = 1'b0; par_in = '0; cap_strobe = 0; shift_strobe = 0;
    ser_in = 0; copy_n = 1; clear_n = 1;
    tick(3);
    chk("R11 reset ser_out", ser_out, 0);
    chk("R11 reset fault", fault, 0);
    rst_n = 1'b1; tick(3);
    do_copy();
    chk("R11 holding cleared by reset", ser_out, 0);

    // R6/R5/R3: every word copied, shifted out, complement follows
    for (int v = 0; v < 256; v++) begin
      capture(W'(v));
      do_copy();
      drain("R6 copied word", W'(v), ~W'(v));
      drain("R5 serial bits follow", ~W'(v), '0);
    end

    // R10: action on the third clock after the strobe is sampled high
    capture(8'h00); do_copy();
    par_in = 8'hFF; copy_n = 1'b0; cap_strobe = 1'b1;
    tick(2);
    chk("R10 not yet captured", ser_out, 0);
    tick(1);
    chk("R10 captured on third edge", ser_out, 1);
    copy_n = 1'b1; cap_strobe = 1'b0; tick(4);

    // R8: copy held for exactly the capture-edge cycle
    capture(8'h3C); do_copy();
    par_in = 8'hA5; cap_strobe = 1'b1;
    tick(2); copy_n = 1'b0; tick(1); copy_n = 1'b1;
    tick(3); cap_strobe = 1'b0; tick(4);
    drain("R8 new word reaches shift register", 8'hA5, '0);

    // R9/R2: capture edge does not shift; shift register keeps old copy
    capture(8'hC3); do_copy();
    capture(8'h5A);
    drain("R9 capture edge does not shift", 8'hC3, '0);
    do_copy();
    drain("R2 holding kept through shifts", 8'h5A, '0);

    // R4 and R1: clear empties; capture still works during clear
    capture(8'hFF); do_copy();
    clear_n = 1'b0; tick(2);
    chk("R4 clear gives zero", ser_out, 0);
    capture(8'h81);
    shift_one(1'b1);
    clear_n = 1'b1; tick(1);
    drain("R9 shift ignored in clear", 8'h00, '0);
    do_copy();
    drain("R1 capture during clear", 8'h81, '0);

    // R9: shift ignored during copy
    capture(8'h96); copy_n = 1'b0; tick(1);
    shift_one(1'b0);
    chk("R9 shift ignored in copy", ser_out, 1);
    copy_n = 1'b1; tick(1);
    drain("R9 word intact after copy", 8'h96, '0);

    // R7: conflict
    capture(8'hF0); do_copy();
    copy_n = 1'b0; clear_n = 1'b0; tick(1);
    chk("R7 fault raised", fault, 1);
    chk("R7 register zero", ser_out, 0);
    copy_n = 1'b1; clear_n = 1'b1; tick(1);
    chk("R7 fault released", fault, 0);
    drain("R7 register zero after fault", 8'h00, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule